// File: doc/BRIEF.md
# Block-Chained Long-Instruction Fetch Sequencer

This block produces the fetch address for a wide-issue engine that reads one long instruction per cycle from a cache whose lines each hold a whole block of long instructions. The fetch address has two fields: an ISA address that names the block, and a slot index that picks one long instruction inside it. A small per-line table, filled while blocks are written into the cache, holds each line's end-of-block record. That record gives the slot index of the block's final long instruction and the ISA address of the block that follows it.

While the engine runs, each cycle's lookup reports a hit and the line number. The sequencer reads that line's end-of-block record in the same cycle. It either steps to the next slot or, on the final slot, jumps straight to the following block at slot 0 with no lost cycle. A branch found to go against its recorded direction overrides both choices: the fetch in flight is dropped and the sequencer restarts at the corrected target. A lookup that misses stops the engine, raises a one-cycle handback pulse and freezes the fetch address so the scalar core can resume from it. A start request from the scalar side brings the engine back.

Top module: `vliw_fetch_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `fetch_en_o`, `slot_valid_o` and `miss_o` are 0 and `pc_addr_o` and `pc_idx_o` are 0.
- R2: With `fetch_en_o` low, a cycle with `start_i` high makes the next cycle show `fetch_en_o`=1, `pc_addr_o`=`start_addr_i` and `pc_idx_o`=0. `start_i` has no effect while `fetch_en_o` is high.
- R3: With `fetch_en_o` high, `hit_i` high, `mispredict_i` low and `pc_idx_o` different from the end index stored for `hit_line_i`, the next cycle shows `pc_idx_o`+1 and the same `pc_addr_o`.
- R4: With `fetch_en_o` high, `hit_i` high, `mispredict_i` low and `pc_idx_o` equal to the stored end index, the next cycle shows `pc_addr_o` = the stored follow-on address and `pc_idx_o`=0, with `slot_valid_o` still 1 (no bubble).
- R5: A cycle with `save_valid_i` high writes {`save_next_addr_i`, `save_index_i`} as the end-of-block record of line `save_line_i`. A later write to the same line replaces it, so the last saved long instruction decides the record.
- R6: With `fetch_en_o` high and `mispredict_i` high, the next cycle shows `pc_addr_o`=`redirect_addr_i`, `pc_idx_o`=0, `fetch_en_o`=1 and `slot_valid_o`=0. The cycle after that shows `slot_valid_o`=1 again if the new fetch hits, which makes exactly one bubble.
- R7: A misprediction takes priority over chaining, over stepping and over a miss reported in the same cycle.
- R8: With `fetch_en_o` high, `hit_i` low and `mispredict_i` low, the next cycle shows `fetch_en_o`=0 and `miss_o`=1, and `pc_addr_o`/`pc_idx_o` unchanged. `miss_o` is high for that one cycle only. While `fetch_en_o` is low, the fetch address holds and `hit_i` and `mispredict_i` have no effect.
- R9: `slot_valid_o` is 1 exactly when the previous cycle had `fetch_en_o`=1, `hit_i`=1 and `mispredict_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Scalar side hands control to the engine |
| start_addr_i | input | ADDR_W | ISA address at which the engine starts |
| hit_i | input | 1 | Lookup for the current fetch address hit |
| hit_line_i | input | LINE_W | Cache line that hit |
| mispredict_i | input | 1 | Execute stage found a branch against its recorded direction |
| redirect_addr_i | input | ADDR_W | Corrected branch target |
| save_valid_i | input | 1 | One long instruction of a block is being saved |
| save_line_i | input | LINE_W | Line receiving the saved long instruction |
| save_next_addr_i | input | ADDR_W | Follow-on address carried by that long instruction |
| save_index_i | input | IDX_W | Slot index of that long instruction |
| fetch_en_o | output | 1 | Engine owns fetch |
| pc_addr_o | output | ADDR_W | ISA address field of the fetch address |
| pc_idx_o | output | IDX_W | Slot index field of the fetch address |
| slot_valid_o | output | 1 | The previous cycle's fetch is live |
| miss_o | output | 1 | One-cycle handback pulse after a miss |

## Verification
A wrong end-of-block record or a bad index compare shows up on the very next edge. The sequencer either chains one slot too early, with `pc_addr_o` jumping while `pc_idx_o` is mid-block, or walks past the block end instead of clearing `pc_idx_o`. A wrong priority between redirect and chaining shows in the same one-cycle window: `pc_addr_o` takes the follow-on address rather than the corrected target. A stuck active flag or handback pulse shows as `miss_o` lasting two cycles or as the fetch address drifting while the engine is idle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Source that loads the fetch address on the next edge.
  typedef enum logic [2:0] {
    SRC_HOLD     = 3'd0,
    SRC_START    = 3'd1,
    SRC_STEP     = 3'd2,
    SRC_CHAIN    = 3'd3,
    SRC_REDIRECT = 3'd4,
    SRC_MISS     = 3'd5
  } pc_src_e;

endpackage

// File: rtl/fseq_nba_store.sv
module fseq_nba_store #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int LINES  = 16,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] rd_line,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  rd_idx
);

  localparam int ENT_W = ADDR_W + IDX_W;

  // One end-of-block record per line; read is same-cycle for chaining.
  logic [ENT_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_line] <= {wr_addr, wr_idx};
  end

  assign {rd_addr, rd_idx} = mem[rd_line];

endmodule

// File: rtl/fseq_next_sel.sv
module fseq_next_sel
  import fseq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             active,
  input  logic             start,
  input  logic             hit,
  input  logic             mispredict,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] end_idx,
  output pc_src_e          src
);

  logic at_end;
  assign at_end = (cur_idx == end_idx);

  // Priority while running: redirect, then miss, then chain, then step.
  always_comb begin
    src = SRC_HOLD;
    if (!active) begin
      if (start) src = SRC_START;
    end else if (mispredict) begin
      src = SRC_REDIRECT;
    end else if (!hit) begin
      src = SRC_MISS;
    end else if (at_end) begin
      src = SRC_CHAIN;
    end else begin
      src = SRC_STEP;
    end
  end

endmodule

// File: rtl/fseq_pc_unit.sv
module fseq_pc_unit
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_src_e           src,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] chain_addr,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [IDX_W-1:0]  pc_idx
);

  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_addr <= '0;
      pc_idx  <= '0;
    end else begin
      unique case (src)
        SRC_START: begin
          pc_addr <= start_addr;
          pc_idx  <= '0;
        end
        SRC_REDIRECT: begin
          pc_addr <= tgt_addr;
          pc_idx  <= '0;
        end
        SRC_CHAIN: begin
          pc_addr <= chain_addr;
          pc_idx  <= '0;
        end
        SRC_STEP: pc_idx <= pc_idx + IDX_ONE;
        default: ;
      endcase
    end
  end

  // R3: a step never changes the address field.
  p_step_keeps_addr_r3: assert property (@(posedge clk) disable iff (rst)
    src == SRC_STEP |=> $stable(pc_addr) && pc_idx == $past(pc_idx) + IDX_ONE);

  // R8: hold and miss leave both fields untouched.
  p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_HOLD || src == SRC_MISS) |=> $stable(pc_addr) && $stable(pc_idx));

endmodule

// File: rtl/vliw_fetch_seq.sv
module vliw_fetch_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLOCK_LEN = 8,
  parameter int NUM_LINES = 16,
  localparam int IDX_W  = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              hit_i,
  input  logic [LINE_W-1:0] hit_line_i,
  input  logic              mispredict_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  input  logic              save_valid_i,
  input  logic [LINE_W-1:0] save_line_i,
  input  logic [ADDR_W-1:0] save_next_addr_i,
  input  logic [IDX_W-1:0]  save_index_i,
  output logic              fetch_en_o,
  output logic [ADDR_W-1:0] pc_addr_o,
  output logic [IDX_W-1:0]  pc_idx_o,
  output logic              slot_valid_o,
  output logic              miss_o
);

  logic [ADDR_W-1:0] nba_addr;
  logic [IDX_W-1:0]  nba_idx;
  pc_src_e           src;

  fseq_nba_store #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .LINES  (NUM_LINES)
  ) u_nba (
    .clk     (clk),
    .wr_en   (save_valid_i),
    .wr_line (save_line_i),
    .wr_addr (save_next_addr_i),
    .wr_idx  (save_index_i),
    .rd_line (hit_line_i),
    .rd_addr (nba_addr),
    .rd_idx  (nba_idx)
  );

  fseq_next_sel #(
    .IDX_W (IDX_W)
  ) u_sel (
    .active     (fetch_en_o),
    .start      (start_i),
    .hit        (hit_i),
    .mispredict (mispredict_i),
    .cur_idx    (pc_idx_o),
    .end_idx    (nba_idx),
    .src        (src)
  );

  fseq_pc_unit #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_pc (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .start_addr (start_addr_i),
    .tgt_addr   (redirect_addr_i),
    .chain_addr (nba_addr),
    .pc_addr    (pc_addr_o),
    .pc_idx     (pc_idx_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_en_o   <= 1'b0;
      miss_o       <= 1'b0;
      slot_valid_o <= 1'b0;
    end else begin
      if (src == SRC_START)     fetch_en_o <= 1'b1;
      else if (src == SRC_MISS) fetch_en_o <= 1'b0;
      miss_o       <= (src == SRC_MISS);
      slot_valid_o <= (src == SRC_STEP) || (src == SRC_CHAIN);
    end
  end

  // R2: a start from idle lands at slot 0 of the given address.
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    !fetch_en_o && start_i |=> fetch_en_o && pc_addr_o == $past(start_addr_i) && pc_idx_o == '0);

  // R3: stepping inside a block.
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o && hit_i && !mispredict_i && pc_idx_o != nba_idx
    |=> slot_valid_o && fetch_en_o && $stable(pc_addr_o));

  // R4: chaining to the follow-on block with no bubble.
  p_chain_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o && hit_i && !mispredict_i && pc_idx_o == nba_idx
    |=> pc_addr_o == $past(nba_addr) && pc_idx_o == '0 && slot_valid_o);

  // R6, R7: redirect wins and leaves exactly one dead slot.
  p_redirect_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o && mispredict_i
    |=> fetch_en_o && pc_addr_o == $past(redirect_addr_i) && pc_idx_o == '0 && !slot_valid_o);

  // R8: a miss hands control back and freezes the address.
  p_miss_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o && !hit_i && !mispredict_i
    |=> !fetch_en_o && miss_o && $stable(pc_addr_o) && $stable(pc_idx_o));

  // R8: the handback pulse is one cycle long.
  p_miss_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    miss_o |=> !miss_o);

  // R9: nothing is live while the engine is idle.
  p_idle_dead_r9: assert property (@(posedge clk) disable iff (rst)
    !fetch_en_o |=> !slot_valid_o);

endmodule

// File: tb/tb_vliw_fetch_seq.sv
module tb_vliw_fetch_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam int LINE_W = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              start_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic              hit_i;
  logic [LINE_W-1:0] hit_line_i;
  logic              mispredict_i;
  logic [ADDR_W-1:0] redirect_addr_i;
  logic              save_valid_i;
  logic [LINE_W-1:0] save_line_i;
  logic [ADDR_W-1:0] save_next_addr_i;
  logic [IDX_W-1:0]  save_index_i;
  logic              fetch_en_o;
  logic [ADDR_W-1:0] pc_addr_o;
  logic [IDX_W-1:0]  pc_idx_o;
  logic              slot_valid_o;
  logic              miss_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_fetch_seq dut (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .start_addr_i     (start_addr_i),
    .hit_i            (hit_i),
    .hit_line_i       (hit_line_i),
    .mispredict_i     (mispredict_i),
    .redirect_addr_i  (redirect_addr_i),
    .save_valid_i     (save_valid_i),
    .save_line_i      (save_line_i),
    .save_next_addr_i (save_next_addr_i),
    .save_index_i     (save_index_i),
    .fetch_en_o       (fetch_en_o),
    .pc_addr_o        (pc_addr_o),
    .pc_idx_o         (pc_idx_o),
    .slot_valid_o     (slot_valid_o),
    .miss_o           (miss_o)
  );

  typedef struct packed {
    logic        st;
    logic [31:0] sa;
    logic        hit;
    logic [3:0]  ln;
    logic        mis;
    logic [31:0] tg;
    logic        en;
    logic [31:0] ea;
    logic [2:0]  ei;
    logic        sl;
    logic        ms;
  } vec_t;

  // Inputs applied for one cycle, then outputs expected after that edge.
  // End records: line1 = {0x200, 2}, line2 = {0x300, 1}, line3 = {0x100, 7}.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h100, 1'b0, 4'd0, 1'b0, 32'h0,   1'b1, 32'h100, 3'd0, 1'b0, 1'b0}, // R2 start
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b0, 32'h0,   1'b1, 32'h100, 3'd1, 1'b1, 1'b0}, // R3 step
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b0, 32'h0,   1'b1, 32'h100, 3'd2, 1'b1, 1'b0}, // R3 step
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b0, 32'h0,   1'b1, 32'h200, 3'd0, 1'b1, 1'b0}, // R4 chain
    '{1'b0, 32'h0,   1'b1, 4'd2, 1'b0, 32'h0,   1'b1, 32'h200, 3'd1, 1'b1, 1'b0}, // R3 step
    '{1'b0, 32'h0,   1'b1, 4'd2, 1'b0, 32'h0,   1'b1, 32'h300, 3'd0, 1'b1, 1'b0}, // R5 last save wins
    '{1'b0, 32'h0,   1'b1, 4'd3, 1'b1, 32'h180, 1'b1, 32'h180, 3'd0, 1'b0, 1'b0}, // R6 redirect bubble
    '{1'b0, 32'h0,   1'b1, 4'd3, 1'b0, 32'h0,   1'b1, 32'h180, 3'd1, 1'b1, 1'b0}, // R6 single bubble
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b0, 32'h0,   1'b1, 32'h180, 3'd2, 1'b1, 1'b0}, // R3 step
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b1, 32'h400, 1'b1, 32'h400, 3'd0, 1'b0, 1'b0}, // R7 redirect over chain
    '{1'b0, 32'h0,   1'b0, 4'd0, 1'b0, 32'h0,   1'b0, 32'h400, 3'd0, 1'b0, 1'b1}, // R8 miss
    '{1'b0, 32'h0,   1'b0, 4'd0, 1'b0, 32'h0,   1'b0, 32'h400, 3'd0, 1'b0, 1'b0}, // R8 pulse ends
    '{1'b0, 32'h0,   1'b1, 4'd1, 1'b1, 32'h777, 1'b0, 32'h400, 3'd0, 1'b0, 1'b0}, // R8 idle ignores
    '{1'b1, 32'h300, 1'b0, 4'd0, 1'b0, 32'h0,   1'b1, 32'h300, 3'd0, 1'b0, 1'b0}  // R2 restart
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic en, input logic [31:0] a,
                           input logic [2:0] i, input logic sl, input logic ms);
    chk({tag, " fetch_en"},   64'(fetch_en_o),   64'(en));
    chk({tag, " pc_addr"},    64'(pc_addr_o),    64'(a));
    chk({tag, " pc_idx"},     64'(pc_idx_o),     64'(i));
    chk({tag, " slot_valid"}, 64'(slot_valid_o), 64'(sl));
    chk({tag, " miss"},       64'(miss_o),       64'(ms));
  endtask

  task automatic drive(input logic st, input logic [31:0] sa, input logic h,
                       input logic [3:0] ln, input logic m, input logic [31:0] tg);
    @(negedge clk);
    start_i = st; start_addr_i = sa; hit_i = h; hit_line_i = ln;
    mispredict_i = m; redirect_addr_i = tg;
    @(posedge clk);
    #1;
  endtask

  task automatic save(input logic [3:0] ln, input logic [31:0] a, input logic [2:0] i);
    @(negedge clk);
    save_valid_i = 1'b1; save_line_i = ln; save_next_addr_i = a; save_index_i = i;
    @(negedge clk);
    save_valid_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; start_addr_i = '0; hit_i = 1'b0; hit_line_i = '0;
    mispredict_i = 1'b0; redirect_addr_i = '0; save_valid_i = 1'b0; save_line_i = '0;
    save_next_addr_i = '0; save_index_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset", 1'b0, 32'h0, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1 after release", 1'b0, 32'h0, 3'd0, 1'b0, 1'b0);

    // R5: end records; line2 is written twice and the second must stick.
    save(4'd1, 32'h200, 3'd2);
    save(4'd2, 32'hAAA, 3'd5);
    save(4'd2, 32'h300, 3'd1);
    save(4'd3, 32'h100, 3'd7);
    chk("R5 idle during saves", 64'(fetch_en_o), 64'd0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].st, VEC[k].sa, VEC[k].hit, VEC[k].ln, VEC[k].mis, VEC[k].tg);
      check_all($sformatf("vector %0d", k), VEC[k].en, VEC[k].ea, VEC[k].ei, VEC[k].sl, VEC[k].ms);
    end

    // R3: walk a full eight-slot block on line3, then R4 chains at slot 7.
    for (int k = 1; k < 8; k++) begin
      drive(1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 32'h0);
      check_all($sformatf("R3 walk slot %0d", k), 1'b1, 32'h300, 3'(k), 1'b1, 1'b0);
    end
    drive(1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 32'h0);
    check_all("R4 chain after slot 7", 1'b1, 32'h100, 3'd0, 1'b1, 1'b0);

    // R2: start while running has no effect.
    drive(1'b1, 32'h999, 1'b1, 4'd1, 1'b0, 32'h0);
    check_all("R2 start ignored when running", 1'b1, 32'h100, 3'd1, 1'b1, 1'b0);

    // R7: redirect beats a miss in the same cycle.
    drive(1'b0, 32'h0, 1'b0, 4'd0, 1'b1, 32'h600);
    check_all("R7 redirect over miss", 1'b1, 32'h600, 3'd0, 1'b0, 1'b0);

    // R9: a hit after the bubble makes the slot live again.
    drive(1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 32'h0);
    check_all("R9 live after bubble", 1'b1, 32'h600, 3'd1, 1'b1, 1'b0);

    // R1: reset in mid-run.
    @(negedge clk);
    rst = 1'b1; hit_i = 1'b1; hit_line_i = 4'd3;
    @(posedge clk);
    #1;
    check_all("R1 mid-run reset", 1'b0, 32'h0, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0; hit_i = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule